// File: doc/BRIEF.md
# Clock-Recovery Lock-Mode Switchover Controller

This block chooses whether a clock-recovery loop follows the reference clock or the incoming serial data. Two override inputs can force either choice. With both overrides low, the block runs in automatic mode. In that mode a windowed frequency comparator checks the recovered clock against the reference clock. Data tracking is allowed only after that comparison shows the recovered clock is close enough to the reference.

The whole block runs in the reference clock domain. The recovered clock is reduced to a small per-cycle edge count, `rec_tick`, which tells how many recovered edges fell inside each reference cycle. The window length and the parts-per-million tolerance are parameters. The tolerance is turned into an integer count limit when the block is elaborated. The outputs drive the loop's lock-to-data select and a frequency-locked status flag.

Top module: `cdr_lock_switch`

## Requirements
- R1: While `force_data` is 1, `lock_to_data` is 1 after the next clock edge, whatever the value of `force_ref`.
- R2: While `force_data` is 0 and `force_ref` is 1, `lock_to_data` is 0 after the next clock edge, even when the recovered clock is exactly on frequency.
- R3: With both override inputs at 0, the block is in automatic mode. In automatic mode the lock decision depends only on the frequency windows.
- R4: A window is WIN_CYCLES reference cycles long. Over a window, the block sums `rec_tick`, which takes the values 0 to 3. The window is in tolerance when |sum − WIN_CYCLES| ≤ floor(WIN_CYCLES × THRESH_PPM / 1e6). In automatic mode, `lock_to_data` can rise only at the edge that ends an in-tolerance window.
- R5: In automatic mode, two in-tolerance windows in a row are needed to enter data tracking. An out-of-tolerance window between two good windows sends the count of good windows back to zero.
- R6: In automatic mode while locked, a single out-of-tolerance window clears `lock_to_data` at the edge that ends that window.
- R7: `freq_locked` equals `lock_to_data` in every cycle: it is high exactly in the lock-to-data state.
- R8: After reset, `lock_to_data` and `freq_locked` are 0, and the block is in automatic mode with an empty window.
- R9: Any change in the decoded override mode takes effect at the next edge. That edge also empties the window counters. Entering automatic mode starts the block from reference tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_data | input | 1 | Override: force data tracking (wins over force_ref) |
| force_ref | input | 1 | Override: force reference tracking |
| rec_tick | input | TICK_W | Recovered-clock edges seen in this reference cycle |
| lock_to_data | output | 1 | 1 = loop tracks data, 0 = loop tracks reference |
| freq_locked | output | 1 | Frequency-locked status |

## Verification
Forced-mode results are due one edge after the override inputs change. A window verdict is due at the WIN_CYCLES-th edge after the edge that emptied the window: the restart edge, or the end of the previous window. The bench changes the inputs 1 ns after each rising edge and samples the outputs at that same point. Each check therefore falls exactly after the edge whose result it expects. The bench counts edges from a known restart edge, which it makes by pulsing `force_ref` for one cycle. Expected lock values come from the delta of recovered edges that the bench itself placed in each window, compared with the floor limit.

// File: rtl/cdr_lock_switch_pkg.sv
// Package: shared types for the lock-mode switchover controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cdr_lock_switch_pkg;

    // Decoded override mode
    typedef enum logic [1:0] {
        MODE_AUTO = 2'd0,
        MODE_REF  = 2'd1,
        MODE_DATA = 2'd2
    } sw_mode_t;

    // Lock tracking state
    typedef enum logic [1:0] {
        ST_REF  = 2'd0,
        ST_PEND = 2'd1,
        ST_DATA = 2'd2
    } sw_state_t;

endpackage

// File: rtl/cdr_override_decode.sv
// Module: decodes the two override pins into a mode and flags a mode change.
// Assumes: inputs are synchronous to clk; data override has priority.
module cdr_override_decode
    import cdr_lock_switch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     force_data,
    input  logic     force_ref,
    output sw_mode_t mode_sel,
    output logic     mode_chg
);

    sw_mode_t mode_q;

    // Priority decode of the override pins
    always_comb begin
        if (force_data)
            mode_sel = MODE_DATA;
        else if (force_ref)
            mode_sel = MODE_REF;
        else
            mode_sel = MODE_AUTO;
    end

    // Remember the mode applied at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_AUTO;
        else
            mode_q <= mode_sel;
    end

    // A change is any difference from the last applied mode
    always_comb mode_chg = (mode_sel != mode_q);

endmodule

// File: rtl/cdr_freq_window.sv
// Module: counts recovered edges over a fixed window of reference cycles and
// judges the total against an integer tolerance derived from a PPM setting.
// Assumes: WIN_CYCLES >= 2; rec_tick holds the edges seen in one cycle.
module cdr_freq_window #(
    parameter int unsigned WIN_CYCLES = 1000,
    parameter int unsigned THRESH_PPM = 2000,
    parameter int unsigned TICK_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           restart,
    input  logic [TICK_W-1:0]              rec_tick,
    output logic                           win_done,
    output logic                           win_ok,
    output logic [$clog2(WIN_CYCLES)-1:0]  win_cnt
);

    localparam int unsigned WIN_W    = $clog2(WIN_CYCLES);
    localparam int unsigned MAX_TICK = (1 << TICK_W) - 1;
    localparam int unsigned CNT_W    = $clog2(WIN_CYCLES * MAX_TICK + 1);
    localparam logic [63:0] LIMIT64  =
        (64'(WIN_CYCLES) * 64'(THRESH_PPM)) / 64'd1000000;
    localparam logic [63:0] CNT_MAX  = 64'((64'd1 << CNT_W) - 64'd1);
    localparam logic [CNT_W-1:0] LIMIT =
        (LIMIT64 > CNT_MAX) ? {CNT_W{1'b1}} : LIMIT64[CNT_W-1:0];
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(WIN_CYCLES);
    localparam logic [WIN_W-1:0] LAST   = WIN_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] delta;
    logic             at_end;

    // Window end is the last cycle, unless a restart overrides it
    always_comb at_end = (win_cnt == LAST);
    always_comb win_done = at_end && !restart;

    // Count including the current cycle's edges
    always_comb total = edge_cnt + CNT_W'(rec_tick);

    // Absolute distance from the ideal count
    always_comb begin
        if (total >= TARGET)
            delta = total - TARGET;
        else
            delta = TARGET - total;
    end

    // Tolerance verdict, meaningful when win_done is high
    always_comb win_ok = (delta <= LIMIT);

    // Reference-cycle counter for the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (restart || at_end)
            win_cnt <= '0;
        else
            win_cnt <= win_cnt + 1'b1;
    end

    // Recovered-edge accumulator for the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (restart || at_end)
            edge_cnt <= '0;
        else
            edge_cnt <= total;
    end

endmodule

// File: rtl/cdr_lock_fsm.sv
// Module: lock-tracking state machine. Forced modes set the state directly.
// Automatic mode needs two good windows in a row to lock and drops on one bad one.
// Assumes: win_done is already suppressed on a restart edge.
module cdr_lock_fsm
    import cdr_lock_switch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sw_mode_t mode_sel,
    input  logic     mode_chg,
    input  logic     win_done,
    input  logic     win_ok,
    output logic     lock_q,
    output logic     flk_q
);

    sw_state_t state_q;
    sw_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (mode_sel)
            MODE_DATA: state_d = ST_DATA;
            MODE_REF:  state_d = ST_REF;
            default: begin
                if (mode_chg) begin
                    state_d = ST_REF;
                end else if (win_done) begin
                    unique case (state_q)
                        ST_REF:  state_d = win_ok ? ST_PEND : ST_REF;
                        ST_PEND: state_d = win_ok ? ST_DATA : ST_REF;
                        ST_DATA: state_d = win_ok ? ST_DATA : ST_REF;
                        default: state_d = ST_REF;
                    endcase
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_REF;
        else
            state_q <= state_d;
    end

    // Registered lock select
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else
            lock_q <= (state_d == ST_DATA);
    end

    // Registered status flag, kept in its own flop
    always_ff @(posedge clk) begin
        if (!rst_n)
            flk_q <= 1'b0;
        else
            flk_q <= (state_d == ST_DATA);
    end

endmodule

// File: rtl/cdr_lock_switch.sv
// Module: top of the lock-mode switchover controller. Decodes the overrides,
// runs the windowed frequency check and drives the lock select and status.
// Assumes: one clock domain (reference); rec_tick is already in that domain.
module cdr_lock_switch
    import cdr_lock_switch_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 1000,
    parameter int unsigned THRESH_PPM = 2000,
    parameter int unsigned TICK_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_data,
    input  logic              force_ref,
    input  logic [TICK_W-1:0] rec_tick,
    output logic              lock_to_data,
    output logic              freq_locked
);

    localparam int unsigned WIN_W = $clog2(WIN_CYCLES);

    sw_mode_t         mode_sel;
    logic             mode_chg;
    logic             win_done;
    logic             win_ok;
    logic [WIN_W-1:0] win_cnt;

    cdr_override_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_data (force_data),
        .force_ref  (force_ref),
        .mode_sel   (mode_sel),
        .mode_chg   (mode_chg)
    );

    cdr_freq_window #(
        .WIN_CYCLES (WIN_CYCLES),
        .THRESH_PPM (THRESH_PPM),
        .TICK_W     (TICK_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (mode_chg),
        .rec_tick (rec_tick),
        .win_done (win_done),
        .win_ok   (win_ok),
        .win_cnt  (win_cnt)
    );

    cdr_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .mode_chg (mode_chg),
        .win_done (win_done),
        .win_ok   (win_ok),
        .lock_q   (lock_to_data),
        .flk_q    (freq_locked)
    );

endmodule

// File: rtl/cdr_lock_switch_chk.sv
// Module: assertion checker for the switchover controller, bound to the top.
// Assumes: synchronous active-low reset; all signals in the clk domain.
module cdr_lock_switch_chk #(
    parameter int unsigned WIN_W = 10,
    parameter int unsigned LAST  = 999
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_data,
    input logic             force_ref,
    input logic             lock_to_data,
    input logic             freq_locked,
    input logic             win_done,
    input logic             win_ok,
    input logic             mode_chg,
    input logic [WIN_W-1:0] win_cnt
);

    AST_FORCE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        force_data |=> lock_to_data); // R1

    AST_FORCE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_data && force_ref) |=> !lock_to_data); // R2

    AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_to_data) && !$past(force_data)) |-> $past(win_done && win_ok)); // R4

    AST_AUTO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_data && !force_ref && lock_to_data && win_done && !win_ok)
        |=> !lock_to_data); // R6

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        freq_locked == lock_to_data); // R7

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (win_cnt == '0)); // R9

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_W'(LAST)); // R4

endmodule

bind cdr_lock_switch cdr_lock_switch_chk #(
    .WIN_W ($clog2(WIN_CYCLES)),
    .LAST  (WIN_CYCLES - 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_data   (force_data),
    .force_ref    (force_ref),
    .lock_to_data (lock_to_data),
    .freq_locked  (freq_locked),
    .win_done     (win_done),
    .win_ok       (win_ok),
    .mode_chg     (mode_chg),
    .win_cnt      (win_cnt)
);

// File: tb/test_cdr_lock_switch.sv
`timescale 1ns/1ps
// Bench: sweeps the window delta around the tolerance limit and covers the forced modes.
module test_cdr_lock_switch;

    localparam int WIN   = 100;
    localparam int PPM   = 30000;
    localparam int LIMIT = (WIN * PPM) / 1000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_data = 1'b0;
    logic       force_ref = 1'b0;
    logic [1:0] rec_tick = 2'd0;
    logic       lock_to_data;
    logic       freq_locked;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cdr_lock_switch #(
        .WIN_CYCLES (WIN),
        .THRESH_PPM (PPM),
        .TICK_W     (2)
    ) i_cdr_lock_switch (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_data   (force_data),
        .force_ref    (force_ref),
        .rec_tick     (rec_tick),
        .lock_to_data (lock_to_data),
        .freq_locked  (freq_locked)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, then sit 1 ns after the consuming edge
    task automatic drv(input logic fd, input logic fr, input int t);
        force_data = fd;
        force_ref  = fr;
        rec_tick   = t[1:0];
        @(posedge clk);
        #1;
    endtask

    // Restart edge: pulse force_ref, then return to auto mode
    task automatic restart_auto();
        drv(1'b0, 1'b1, 1);
        drv(1'b0, 1'b0, 1);
    endtask

    // One automatic window whose edge total is WIN + d
    task automatic win(input int d);
        int ad;
        ad = (d < 0) ? -d : d;
        for (int i = 0; i < WIN; i++)
            drv(1'b0, 1'b0, (i < ad) ? ((d > 0) ? 2 : 0) : 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 lock after reset", lock_to_data, 1'b0);
        chk("R8 status after reset", freq_locked, 1'b0);
        rst_n = 1'b1;

        // R8/R3: from reset, auto mode; two good windows lock
        win(0);
        chk("R5 one window from reset", lock_to_data, 1'b0);
        win(0);
        chk("R3 auto lock from reset", lock_to_data, 1'b1);
        chk("R7 status tracks lock", freq_locked, 1'b1);

        // R4/R5/R6 sweep of the delta across the limit
        for (int d = -(LIMIT + 2); d <= LIMIT + 2; d++) begin
            automatic logic exp_lock = ((d < 0) ? -d : d) <= LIMIT;
            restart_auto();
            chk("R9 auto entry from reference", lock_to_data, 1'b0);
            win(d);
            chk("R5 single window insufficient", lock_to_data, 1'b0);
            win(d);
            chk("R4 tolerance decision", lock_to_data, exp_lock);
            chk("R7 status matches", freq_locked, exp_lock);
            if (exp_lock) begin
                win((d >= 0) ? LIMIT + 1 : -(LIMIT + 1));
                chk("R6 bad window drops lock", lock_to_data, 1'b0);
                chk("R7 status drops", freq_locked, 1'b0);
            end
        end

        // R5: good, bad, good must not lock
        restart_auto();
        win(0);
        win(LIMIT + 3);
        win(0);
        chk("R5 non-consecutive good windows", lock_to_data, 1'b0);
        win(0);
        chk("R5 consecutive pair locks", lock_to_data, 1'b1);

        // R1: forced data, with and without force_ref, no recovered edges
        drv(1'b1, 1'b0, 0);
        chk("R1 forced data", lock_to_data, 1'b1);
        chk("R7 forced data status", freq_locked, 1'b1);
        drv(1'b1, 1'b1, 0);
        chk("R1 data wins over reference", lock_to_data, 1'b1);

        // R2: forced reference with perfect frequency stays unlocked
        drv(1'b0, 1'b1, 1);
        chk("R2 forced reference", lock_to_data, 1'b0);
        for (int w = 0; w < 3; w++) begin
            for (int i = 0; i < WIN; i++) drv(1'b0, 1'b1, 1);
            chk("R2 reference holds", lock_to_data, 1'b0);
            chk("R7 reference status", freq_locked, 1'b0);
        end

        // R9: a mid-window mode change restarts the window
        restart_auto();
        for (int i = 0; i < WIN / 2; i++) drv(1'b0, 1'b0, 1);
        restart_auto();
        for (int i = 0; i < 2 * WIN - 1; i++) drv(1'b0, 1'b0, 1);
        chk("R9 not yet locked after restart", lock_to_data, 1'b0);
        drv(1'b0, 1'b0, 1);
        chk("R9 locked on second full window", lock_to_data, 1'b1);

        // R9: leaving forced data for auto returns to reference at once
        drv(1'b1, 1'b0, 1);
        drv(1'b0, 1'b0, 1);
        chk("R9 auto entry from forced data", lock_to_data, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule